// File: doc/BRIEF.md
# Chip erase retry controller

This block sequences a whole-array electrical erase of a parallel 16-bit non-volatile memory for a device programmer. It drives digital control lines only: a select that raises the programming supply to the erase level, a select that puts address line A9 at the erase level, active-low chip enable and output enable, and the address bus. It reads the memory's data bus back during verification. Generating the voltages is left to the circuitry around it.

A start strobe begins a run. The block raises the programming supply and issues one timed erase pulse with every address line low. It then walks the array in erase-verify mode, where chip enable is high and output enable is low, and accepts a word only if it reads all ones. A failing word costs one unit of a shared retry budget and triggers another full-array pulse. After that pulse, verification picks up at the word that failed, not at the first word. When the last word passes, the supply is returned to nominal. A second walk in normal read mode must then see all ones at every address.

The result sits on done, pass and fail until the next start. Every duration is a count of clock cycles set by a parameter, so a simulation can use short pulses.

Top module: `chip_clear_seq`

## Requirements
- R1: Out of reset the block is idle: chip enable and output enable high (inactive), supply select low (nominal), A9 select low, done, pass and fail low.
- R2: A start strobe in idle or done clears the retry count and points the walk at address 0. Before every erase pulse, the supply select and the A9 select are both high with chip enable high for exactly SETUP_CYC cycles. For the whole time the A9 select is high, the address bus is all zeros and output enable is high.
- R3: Each erase pulse holds chip enable low for exactly PULSE_CYC cycles. After chip enable rises, the A9 select stays high with the address at zero for exactly HOLD_CYC cycles.
- R4: Erase verify keeps chip enable high, output enable low and the supply select high. It visits ascending addresses, holding each for ACC_CYC cycles, and accepts a word only when the data bus reads 16'hFFFF.
- R5: A word that fails verify adds one to the retry count and starts another pulse sequence. After that pulse, verify resumes at the failing address.
- R6: At most MAX_TRIES erase pulses are issued. If verify fails after the MAX_TRIES-th pulse, the run ends with fail set and no final compare.
- R7: When the last address passes verify, the supply select drops low for SETUP_CYC cycles. The block then reads every address from 0 upward with chip enable and output enable both low, ACC_CYC cycles each. The first word that is not 16'hFFFF ends the run with fail set. If all words match, the run ends with pass set.
- R8: Done, pass and fail hold their values until the next start strobe. Pass and fail are never high together, and the block returns to the idle drive levels while done.
- R9: A start strobe that arrives while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an erase run |
| rd_data_i | input | DATA_W | Data bus read back from the memory |
| supply_hi_o | output | 1 | 1 = programming supply at erase level, 0 = nominal |
| a9_hv_o | output | 1 | 1 = A9 driven to the erase level |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with a clean array |
| fail_o | output | 1 | Run finished with an error |

## Verification
The bench builds the block with an 8-word array (ADDR_W = 3) and a budget of four pulses. Its pulse, setup, hold and access counts are a few cycles each, so one complete run lasts under a hundred cycles. At that size the bench can sweep every address through every number of pulses a word may need, from one up to one beyond the budget. This reaches resumption at every position, success on exactly the last allowed pulse, and exhaustion of the budget. A further sweep places a word that passes erase verify but misreads at nominal supply at each address in turn, so the final compare fails at every position.

// File: rtl/clr_seq_pkg.sv
// Shared types for the chip erase retry controller.
// Assumes: one state register in the top, encoded here.
package clr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_VREAD = 3'd4,
        ST_FSET  = 3'd5,
        ST_FREAD = 3'd6,
        ST_DONE  = 3'd7
    } seq_state_t;

endpackage

// File: rtl/seq_cycle_timer.sv
// Phase timer: counts cycles since the last clear and flags the last cycle
// of a phase whose length is lim.
// Assumes: lim >= 1 and lim stays constant while a phase runs.
module seq_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         expire
);
    logic [W-1:0] cnt;

    assign expire = (cnt == lim - W'(1));

    // count up from zero, saturate on the last cycle of the phase
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/seq_addr_walker.sv
// Address walker: holds the current word address, steps it by one and
// reports the top address.
// Assumes: the controller never steps past the last address.
module seq_addr_walker #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    assign last = (addr == {ADDR_W{1'b1}});

    // rewind to word 0 or advance by one word
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/seq_retry_budget.sv
// Retry budget: counts failed verifies and flags when one more failure
// would use up the budget.
// Assumes: MAX_TRIES >= 1; inc is never raised once exhausted is set.
module seq_retry_budget #(
    parameter int MAX_TRIES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CW = $clog2(MAX_TRIES) + 1;

    logic [CW-1:0] cnt;

    assign exhausted = (cnt == CW'(MAX_TRIES - 1));

    // one more spent pulse per failed verify
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R6: the count of spent retries stays below the budget
    a_r6_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAX_TRIES));

    // R6: the controller never asks for a retry past the budget
    a_r6_no_inc_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |-> !inc);
endmodule

// File: rtl/chip_clear_seq.sv
// Chip erase retry controller (top).
// Runs: setup -> erase pulse -> hold -> word-by-word erase verify, with
// another pulse on each failing word under a shared budget, then a final
// compare at nominal supply. Results are held until the next start.
// Assumes: memory data is valid ACC_CYC cycles after address and enables
// settle; all cycle counts >= 1.
module chip_clear_seq
    import clr_seq_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int MAX_TRIES = 20,
    parameter int SETUP_CYC = 250,
    parameter int PULSE_CYC = 12500000,
    parameter int HOLD_CYC  = 250,
    parameter int ACC_CYC   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              supply_hi_o,
    output logic              a9_hv_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o
);
    localparam int T1   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int T2   = (T1 > HOLD_CYC) ? T1 : HOLD_CYC;
    localparam int TMAX = (T2 > ACC_CYC) ? T2 : ACC_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    seq_state_t        st, nxt;
    logic              t_clr, t_exp;
    logic [TW-1:0]     t_lim;
    logic              w_clr, w_inc, w_last;
    logic [ADDR_W-1:0] w_addr;
    logic              r_clr, r_inc, r_spent;
    logic              set_pass, set_fail, take_start;
    logic              word_ok;

    seq_cycle_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .lim(t_lim), .expire(t_exp)
    );

    seq_addr_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(w_clr), .inc(w_inc),
        .addr(w_addr), .last(w_last)
    );

    seq_retry_budget #(.MAX_TRIES(MAX_TRIES)) u_budget (
        .clk(clk), .rst_n(rst_n), .clr(r_clr), .inc(r_inc), .exhausted(r_spent)
    );

    assign word_ok    = (rd_data_i == ERASED);
    assign take_start = start_i && (st == ST_IDLE || st == ST_DONE);

    // phase length for the current state
    always_comb begin
        case (st)
            ST_SETUP, ST_FSET:  t_lim = TW'(SETUP_CYC);
            ST_PULSE:           t_lim = TW'(PULSE_CYC);
            ST_HOLD:            t_lim = TW'(HOLD_CYC);
            ST_VREAD, ST_FREAD: t_lim = TW'(ACC_CYC);
            default:            t_lim = TW'(1);
        endcase
    end

    // next state and control strobes of the sequence
    always_comb begin
        nxt      = st;
        t_clr    = 1'b0;
        w_clr    = 1'b0;
        w_inc    = 1'b0;
        r_clr    = 1'b0;
        r_inc    = 1'b0;
        set_pass = 1'b0;
        set_fail = 1'b0;
        case (st)
            ST_IDLE, ST_DONE: begin
                if (take_start) begin
                    nxt   = ST_SETUP;
                    t_clr = 1'b1;
                    w_clr = 1'b1;
                    r_clr = 1'b1;
                end
            end
            ST_SETUP: if (t_exp) begin nxt = ST_PULSE; t_clr = 1'b1; end
            ST_PULSE: if (t_exp) begin nxt = ST_HOLD;  t_clr = 1'b1; end
            ST_HOLD:  if (t_exp) begin nxt = ST_VREAD; t_clr = 1'b1; end
            ST_VREAD: begin
                if (t_exp) begin
                    t_clr = 1'b1;
                    if (word_ok) begin
                        if (w_last) begin
                            nxt   = ST_FSET;
                            w_clr = 1'b1;
                        end else begin
                            w_inc = 1'b1;
                        end
                    end else if (r_spent) begin
                        nxt      = ST_DONE;
                        set_fail = 1'b1;
                    end else begin
                        nxt   = ST_SETUP;
                        r_inc = 1'b1;
                    end
                end
            end
            ST_FSET: if (t_exp) begin nxt = ST_FREAD; t_clr = 1'b1; end
            ST_FREAD: begin
                if (t_exp) begin
                    t_clr = 1'b1;
                    if (!word_ok) begin
                        nxt      = ST_DONE;
                        set_fail = 1'b1;
                    end else if (w_last) begin
                        nxt      = ST_DONE;
                        set_pass = 1'b1;
                    end else begin
                        w_inc = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // result flags, cleared by an accepted start and set once per run
    always_ff @(posedge clk) begin
        if (!rst_n || take_start) begin
            done_o <= 1'b0;
            pass_o <= 1'b0;
            fail_o <= 1'b0;
        end else if (set_pass || set_fail) begin
            done_o <= 1'b1;
            pass_o <= set_pass;
            fail_o <= set_fail;
        end
    end

    // pin levels decoded from the state
    always_comb begin
        supply_hi_o = (st == ST_SETUP) || (st == ST_PULSE) ||
                      (st == ST_HOLD)  || (st == ST_VREAD);
        a9_hv_o     = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD);
        ce_n_o      = !((st == ST_PULSE) || (st == ST_FREAD));
        oe_n_o      = !((st == ST_VREAD) || (st == ST_FREAD));
        addr_o      = a9_hv_o ? '0 : w_addr;
    end

    // R2: a pulse only begins after setup levels were already present
    a_r2_pulse_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ce_n_o) && a9_hv_o) |-> ($past(a9_hv_o) && $past(supply_hi_o)));

    // R4: within verify the address only moves up by one word
    a_r4_verify_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o && ce_n_o && $past(!oe_n_o && ce_n_o) && addr_o != $past(addr_o))
        |-> addr_o == $past(addr_o) + ADDR_W'(1));

    // R7: a pass is only declared straight out of a nominal-supply read
    a_r7_pass_from_final: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> ($past(!ce_n_o) && $past(!oe_n_o) && $past(!supply_hi_o)));

    // R8: results are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    // R8: results hold until a start strobe
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_o)));
endmodule

// File: tb/sim_chip_clear_seq.sv
// Bench: small array, behavioural memory whose words need a set number of
// pulses, sweeps of every address against every pulse need and of a
// marginal word at every address.
module sim_chip_clear_seq;
    localparam int AW = 3;
    localparam int NW = 1 << AW;
    localparam int MT = 4;
    localparam int SC = 3;
    localparam int PC = 6;
    localparam int HC = 2;
    localparam int AC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   rd_data;
    logic          supply_hi, a9_hv, ce_n, oe_n, done, pass, fail;
    logic [AW-1:0] addr;

    int n_chk = 0;
    int n_bad = 0;

    // memory model state
    int need [NW];
    int marg = -1;
    int pulses = 0;

    // monitor state
    int  setup_cnt = 0, pulse_len = 0, hold_cnt = 0, vcyc = 0, fcyc = 0;
    int  v2 = 0, v3 = 0, v4 = 0, v7 = 0;
    bit  in_hold = 0, prev_ce = 1, prev_a9 = 0;

    always #4 clk = ~clk;

    chip_clear_seq #(
        .ADDR_W(AW), .DATA_W(16), .MAX_TRIES(MT),
        .SETUP_CYC(SC), .PULSE_CYC(PC), .HOLD_CYC(HC), .ACC_CYC(AC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_data_i(rd_data),
        .supply_hi_o(supply_hi), .a9_hv_o(a9_hv), .ce_n_o(ce_n), .oe_n_o(oe_n),
        .addr_o(addr), .done_o(done), .pass_o(pass), .fail_o(fail)
    );

    // behavioural memory read path
    always_comb begin
        rd_data = 16'h0000;
        if (!oe_n) begin
            if (pulses < need[addr]) rd_data = 16'h00F0;
            else if (!supply_hi && int'(addr) == marg) rd_data = 16'hFFFE;
            else rd_data = 16'hFFFF;
        end
    end

    // pin-level monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (a9_hv) begin
            if (addr != '0 || !oe_n || !supply_hi) v2++;
            if (!ce_n) begin
                if (prev_ce) begin
                    if (setup_cnt != SC) v2++;
                    pulses++;
                    pulse_len = 1;
                end else begin
                    pulse_len++;
                end
            end else if (!prev_ce) begin
                if (pulse_len != PC) v3++;
                in_hold = 1;
                hold_cnt = 1;
            end else if (in_hold) begin
                hold_cnt++;
            end else begin
                setup_cnt++;
            end
        end else if (prev_a9) begin
            if (hold_cnt != HC || !in_hold) v3++;
            in_hold = 0;
            setup_cnt = 0;
        end
        if (ce_n && !oe_n) begin
            vcyc++;
            if (!supply_hi) v4++;
        end
        if (!ce_n && !oe_n) begin
            fcyc++;
            if (supply_hi) v7++;
        end
        prev_ce = ce_n;
        prev_a9 = a9_hv;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic kick();
        @(negedge clk); #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
    endtask

    // one run: expected values from the arithmetic model of the requirements
    task automatic run_case(input int inject_at);
        int p, rv, rf, w;
        bit bad, ok_exp;
        p = 1; rv = 0; rf = 0; bad = 0;
        for (int a = 0; a < NW && !bad; a++) begin
            for (;;) begin
                rv++;
                if (need[a] <= p) break;
                if (p == MT) begin bad = 1; break; end
                p++;
            end
        end
        ok_exp = !bad;
        if (!bad) begin
            for (int a = 0; a < NW; a++) begin
                rf++;
                if (a == marg) begin ok_exp = 0; break; end
            end
        end
        pulses = 0; vcyc = 0; fcyc = 0; v2 = 0; v3 = 0; v4 = 0; v7 = 0;
        setup_cnt = 0; in_hold = 0;
        kick();
        w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
            if (w == inject_at) kick();   // R9: ignored while busy
        end
        chk(done == 1'b1, "R8", "done raised", int'(done), 1);
        chk(pass == ok_exp, "R7", "pass", int'(pass), int'(ok_exp));
        chk(fail == !ok_exp, "R6", "fail", int'(fail), int'(!ok_exp));
        chk(pulses == p, "R6", "pulse count", pulses, p);
        chk(vcyc == AC * rv, "R5", "verify cycles (resume)", vcyc, AC * rv);
        chk(fcyc == AC * rf, "R7", "final compare cycles", fcyc, AC * rf);
        chk(v2 == 0, "R2", "setup/address violations", v2, 0);
        chk(v3 == 0, "R3", "pulse/hold violations", v3, 0);
        chk(v4 == 0, "R4", "verify supply violations", v4, 0);
        chk(v7 == 0, "R7", "final supply violations", v7, 0);
        repeat (5) @(negedge clk);
        chk(done && pass == ok_exp && fail == !ok_exp, "R8", "result held",
            int'(pass), int'(ok_exp));
        chk(ce_n && oe_n && !supply_hi && !a9_hv, "R8", "idle levels while done",
            int'({ce_n, oe_n, supply_hi, a9_hv}), 4'b1100);
    endtask

    // watchdog
    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < NW; a++) need[a] = 1;
        repeat (4) @(negedge clk);
        chk(ce_n && oe_n && !supply_hi && !a9_hv && !done && !pass && !fail,
            "R1", "reset levels",
            int'({ce_n, oe_n, supply_hi, a9_hv, done, pass, fail}), 7'b1100000);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && !done, "R1", "idle after reset",
            int'({ce_n, oe_n, done}), 3'b110);
        // clean array, single pulse
        run_case(0);
        // start strobe in mid-run must not disturb it (R9)
        need[5] = 3;
        run_case(20);
        chk(pulses == 3, "R9", "pulses with stray start", pulses, 3);
        need[5] = 1;
        // sweep: every address, every pulse need up to one past the budget
        for (int a = 0; a < NW; a++) begin
            for (int n = 1; n <= MT + 1; n++) begin
                need[a] = n;
                run_case(0);
            end
            need[a] = 1;
        end
        // mixed needs: resume at several addresses
        need[1] = 2; need[4] = 3; need[6] = 4;
        run_case(0);
        for (int a = 0; a < NW; a++) need[a] = 1;
        // marginal word at each address: fails only the final compare
        for (int a = 0; a < NW; a++) begin
            marg = a;
            run_case(0);
        end
        marg = -1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule